// File: doc/BRIEF.md
# Four-Rail Power Sequencing Controller

This block orders the switching of four supply rails. Once every monitored rail voltage reports good and a settling interval has passed, asserting the enable starts the on-sequence. Each rail's switch-gate enable then rises after that rail's own on-delay. When all four gates are on, a power-good output follows after a further stabilization interval. Removing the enable runs the off-sequence, in which each gate falls after its own off-delay in the soft ramp mode. An undervoltage fault drops every gate at once in the fast pull-down mode.

Several controllers can share one open-drain system-reset line. Any controller, or an outside agent, that pulls the line low forces every gate off in fast mode. A rising edge on the line while the settling interval is still running starts the on-sequence without waiting for that interval to end. A controller pulls the line low while its rails are not good, and again after a sequenced shutdown completes. It releases the line when its rails are good and it is enabled. Analog timing is replaced by counters: the on/off delays are counted in ticks, and the settling and power-good intervals are counter limits.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: While reset is held, every gate_on bit is 0, every gate_fast bit is 1, pgood is 0 and line_pull_low is 1.
- R2: The enable is active when enable_in differs from cfg_en_low. With cfg_en_low=1, a low enable_in starts the on-sequence and a high enable_in keeps all gates off.
- R3: After all undervoltage inputs become good, the enable is ignored for SETTLE_CYC ticks, and no gate turns on in that window unless R10 applies.
- R4: Once settled and enabled, with the line released, gate i rises on_dly[i]+1 cycles after the controller sees the line high. Rail i is bit i, and on_dly[i] is bits [16i+15:16i] of on_dly_cfg. With one clock per tick and the line previously held low by the controller, this is on_dly[i]+5 clocks after the enable changes.
- R5: pgood rises PGOOD_CYC+1 cycles after the last gate turns on. It falls in the same cycle that the enable is deasserted.
- R6: When the enable is deasserted, gate i falls off_dly[i]+2 clocks later, with gate_fast[i] left at 0 (soft ramp). The off-delay field layout is the same as the on-delay layout.
- R7: line_pull_low is 1 while any undervoltage input is bad and after a sequenced shutdown. It is 0 while rails are sequencing or on. It rises in the same cycle that the last gate falls during a sequenced shutdown.
- R8: An undervoltage-low pulse shorter than FILT_CYC clocks has no effect. A longer one turns all gates off with gate_fast all 1, drops pgood and sets line_pull_low.
- R9: A low on line_in turns every gate off with gate_fast 1 within three clocks. When the line rises again while enabled, the on-sequence restarts with no settling wait.
- R10: A rising edge on line_in during the settling interval, with the enable active, starts the on-sequence at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; delay registers load while it is low |
| cfg_en_low | input | 1 | 1 selects an active-low enable |
| enable_in | input | 1 | Sequencing enable, polarity per cfg_en_low |
| uv_ok | input | N_RAIL | Per-rail undervoltage-good inputs (1 = good) |
| line_in | input | 1 | Read-back of the shared wired-AND system-reset line |
| on_dly_cfg | input | N_RAIL*DLY_W | Per-rail on-delays in ticks, rail i at [DLY_W*i +: DLY_W] |
| off_dly_cfg | input | N_RAIL*DLY_W | Per-rail off-delays in ticks, same layout |
| gate_on | output | N_RAIL | Gate enable per rail |
| gate_fast | output | N_RAIL | 1 = fast pull-down mode, 0 = soft ramp mode |
| pgood | output | 1 | Power-good output |
| line_pull_low | output | 1 | Drive-low enable for the open-drain system-reset line |

## Verification
The on-sequence is started in four ways, each with distinct latency. These are the end of the settling lockout, an enable after a completed shutdown, a line release during settling, and a line release after a line-forced kill. Matching exact per-rail rise times in each case separates the settled path, the zero-wait path and the line synchronizer delay. The off-sequence uses different off-delays from the on-delays, so a swapped delay field or a hard instead of soft turn-off shows up. Undervoltage pulses one clock below and two above the filter length separate the filter threshold from the fault response. The polarity case reruns the whole flow with an inverted enable.

// File: rtl/seq_pkg.sv
package seq_pkg;

    typedef enum logic [2:0] {
        S_LOCK   = 3'd0,
        S_SETTLE = 3'd1,
        S_IDLE   = 3'd2,
        S_UP     = 3'd3,
        S_ON     = 3'd4,
        S_DOWN   = 3'd5,
        S_DONE   = 3'd6
    } seq_state_e;

    localparam logic [2:0] MASK_LEN = 3'd5;

endpackage

// File: rtl/seq_uv_filt.sv
module seq_uv_filt #(
    parameter int FILT_CYC = 1750
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_ok,
    output logic filt_ok
);
    localparam int CW = (FILT_CYC > 1) ? $clog2(FILT_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          ok;
    } filt_t;

    filt_t q, n;

    always_comb begin
        n = q;
        if (raw_ok) begin
            n.cnt = '0;
            n.ok  = 1'b1;
        end else if (q.cnt == LAST) begin
            n.ok = 1'b0;
        end else begin
            n.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.cnt <= LAST;
            q.ok  <= 1'b0;
        end else begin
            q <= n;
        end
    end

    assign filt_ok = q.ok;
endmodule

// File: rtl/seq_line_sync.sv
module seq_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_lvl,
    output logic line_rise
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
    } sync_t;

    sync_t q, n;

    always_comb begin
        n.s1   = line_in;
        n.s2   = q.s1;
        n.prev = q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= n;
        end
    end

    assign line_lvl  = q.s2;
    assign line_rise = q.s2 & ~q.prev;
endmodule

// File: rtl/seq_rail.sv
module seq_rail #(
    parameter int DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             up_go,
    input  logic             dn_go,
    input  logic             kill_go,
    input  logic [DLY_W-1:0] on_dly,
    input  logic [DLY_W-1:0] off_dly,
    output logic             gate_on,
    output logic             gate_fast
);
    typedef struct packed {
        logic [DLY_W-1:0] cnt;
        logic             up_arm;
        logic             dn_arm;
        logic             on;
        logic             fast;
    } rail_t;

    rail_t q, n;

    always_comb begin
        n = q;
        if (kill_go) begin
            n.on     = 1'b0;
            n.fast   = 1'b1;
            n.up_arm = 1'b0;
            n.dn_arm = 1'b0;
        end else if (up_go) begin
            n.up_arm = 1'b1;
            n.dn_arm = 1'b0;
            n.cnt    = '0;
        end else if (dn_go) begin
            n.up_arm = 1'b0;
            n.dn_arm = q.on;
            n.cnt    = '0;
        end else if (tick) begin
            if (q.up_arm) begin
                if (q.cnt == on_dly) begin
                    n.on     = 1'b1;
                    n.fast   = 1'b0;
                    n.up_arm = 1'b0;
                end else begin
                    n.cnt = q.cnt + 1'b1;
                end
            end else if (q.dn_arm) begin
                if (q.cnt == off_dly) begin
                    n.on     = 1'b0;
                    n.fast   = 1'b0;
                    n.dn_arm = 1'b0;
                end else begin
                    n.cnt = q.cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.cnt    <= '0;
            q.up_arm <= 1'b0;
            q.dn_arm <= 1'b0;
            q.on     <= 1'b0;
            q.fast   <= 1'b1;
        end else begin
            q <= n;
        end
    end

    assign gate_on   = q.on;
    assign gate_fast = q.fast;
endmodule

// File: rtl/seq_core.sv
module seq_core
    import seq_pkg::*;
#(
    parameter int N_RAIL     = 4,
    parameter int SETTLE_CYC = 10000,
    parameter int PGOOD_CYC  = 160000,
    parameter int TICK_DIV   = 250
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_act,
    input  logic              good_all,
    input  logic              line_lvl,
    input  logic              line_rise,
    input  logic [N_RAIL-1:0] gate_on,
    output logic              tick,
    output logic              up_go,
    output logic              dn_go,
    output logic              kill_go,
    output logic              pgood,
    output logic              pull_low
);
    localparam int SW = $clog2(SETTLE_CYC + 1);
    localparam int PW = $clog2(PGOOD_CYC + 1);
    localparam logic [SW-1:0] SETTLE_LAST = SW'(SETTLE_CYC - 1);
    localparam logic [PW-1:0] PG_LAST     = PW'(PGOOD_CYC - 1);

    typedef struct packed {
        seq_state_e    state;
        logic [SW-1:0] settle_cnt;
        logic [PW-1:0] pg_cnt;
        logic          pg;
        logic          drv;
        logic [2:0]    mask;
    } core_t;

    core_t q, n;
    logic  all_on, all_off;

    assign all_on  = &gate_on;
    assign all_off = ~|gate_on;

    generate
        if (TICK_DIV <= 1) begin : g_notick
            assign tick = 1'b1;
        end else begin : g_tick
            localparam int TW = $clog2(TICK_DIV);
            localparam logic [TW-1:0] T_LAST = TW'(TICK_DIV - 1);
            logic [TW-1:0] tcnt_q, tcnt_d;
            always_comb begin
                tcnt_d = (tcnt_q == T_LAST) ? '0 : tcnt_q + 1'b1;
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) tcnt_q <= '0;
                else        tcnt_q <= tcnt_d;
            end
            assign tick = (tcnt_q == T_LAST);
        end
    endgenerate

    always_comb begin
        n       = q;
        up_go   = 1'b0;
        dn_go   = 1'b0;
        kill_go = 1'b0;
        if (q.mask != 3'd0) n.mask = q.mask - 3'd1;

        case (q.state)
            S_LOCK: begin
                if (good_all) begin
                    n.state      = S_SETTLE;
                    n.settle_cnt = '0;
                end
            end
            S_SETTLE: begin
                if (!good_all) begin
                    n.state = S_LOCK;
                end else if (en_act && line_rise && q.mask == 3'd0) begin
                    n.state = S_UP;
                    up_go   = 1'b1;
                end else if (tick) begin
                    if (q.settle_cnt == SETTLE_LAST) n.state = S_IDLE;
                    else n.settle_cnt = q.settle_cnt + 1'b1;
                end
            end
            S_IDLE: begin
                if (!good_all) begin
                    n.state = S_LOCK;
                end else if (en_act && line_lvl) begin
                    n.state = S_UP;
                    up_go   = 1'b1;
                end
            end
            S_UP, S_ON, S_DOWN: begin
                if (!good_all) begin
                    n.state = S_LOCK;
                    kill_go = 1'b1;
                end else if (!line_lvl) begin
                    n.state = S_IDLE;
                    kill_go = 1'b1;
                end else if (q.state == S_DOWN) begin
                    if (all_off) n.state = S_DONE;
                end else if (!en_act) begin
                    n.state = S_DOWN;
                    dn_go   = 1'b1;
                end else if (q.state == S_UP) begin
                    if (all_on) begin
                        n.state  = S_ON;
                        n.pg_cnt = '0;
                    end
                end else if (tick && !q.pg) begin
                    if (q.pg_cnt == PG_LAST) n.pg = 1'b1;
                    else n.pg_cnt = q.pg_cnt + 1'b1;
                end
            end
            S_DONE: begin
                if (!good_all)   n.state = S_LOCK;
                else if (en_act) n.state = S_IDLE;
            end
            default: n.state = S_LOCK;
        endcase

        if (n.state != S_ON) n.pg = 1'b0;
        n.drv = (n.state == S_LOCK) || (n.state == S_DONE) ||
                ((n.state == S_IDLE) && !en_act);
        if (q.drv && !n.drv) n.mask = MASK_LEN;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state      <= S_LOCK;
            q.settle_cnt <= '0;
            q.pg_cnt     <= '0;
            q.pg         <= 1'b0;
            q.drv        <= 1'b1;
            q.mask       <= 3'd0;
        end else begin
            q <= n;
        end
    end

    assign pgood    = q.pg & en_act & good_all;
    assign pull_low = q.drv | ((q.state == S_DOWN) && all_off);
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl #(
    parameter int N_RAIL     = 4,
    parameter int DLY_W      = 16,
    parameter int FILT_CYC   = 1750,
    parameter int SETTLE_CYC = 10000,
    parameter int PGOOD_CYC  = 160000,
    parameter int TICK_DIV   = 250
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_en_low,
    input  logic                    enable_in,
    input  logic [N_RAIL-1:0]       uv_ok,
    input  logic                    line_in,
    input  logic [N_RAIL*DLY_W-1:0] on_dly_cfg,
    input  logic [N_RAIL*DLY_W-1:0] off_dly_cfg,
    output logic [N_RAIL-1:0]       gate_on,
    output logic [N_RAIL-1:0]       gate_fast,
    output logic                    pgood,
    output logic                    line_pull_low
);
    localparam int CFG_W = N_RAIL * DLY_W;

    logic [CFG_W-1:0]  on_dly_q, off_dly_q;
    logic [N_RAIL-1:0] uv_filt;
    logic              good_all, en_act, line_lvl, line_rise;
    logic              tick, up_go, dn_go, kill_go;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            on_dly_q  <= on_dly_cfg;
            off_dly_q <= off_dly_cfg;
        end
    end

    assign en_act   = enable_in ^ cfg_en_low;
    assign good_all = &uv_filt;

    seq_line_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_in   (line_in),
        .line_lvl  (line_lvl),
        .line_rise (line_rise)
    );

    seq_core #(
        .N_RAIL     (N_RAIL),
        .SETTLE_CYC (SETTLE_CYC),
        .PGOOD_CYC  (PGOOD_CYC),
        .TICK_DIV   (TICK_DIV)
    ) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_act    (en_act),
        .good_all  (good_all),
        .line_lvl  (line_lvl),
        .line_rise (line_rise),
        .gate_on   (gate_on),
        .tick      (tick),
        .up_go     (up_go),
        .dn_go     (dn_go),
        .kill_go   (kill_go),
        .pgood     (pgood),
        .pull_low  (line_pull_low)
    );

    generate
        for (genvar i = 0; i < N_RAIL; i++) begin : g_rail
            seq_uv_filt #(.FILT_CYC(FILT_CYC)) u_filt (
                .clk     (clk),
                .rst_n   (rst_n),
                .raw_ok  (uv_ok[i]),
                .filt_ok (uv_filt[i])
            );
            seq_rail #(.DLY_W(DLY_W)) u_rail (
                .clk       (clk),
                .rst_n     (rst_n),
                .tick      (tick),
                .up_go     (up_go),
                .dn_go     (dn_go),
                .kill_go   (kill_go),
                .on_dly    (on_dly_q[i*DLY_W +: DLY_W]),
                .off_dly   (off_dly_q[i*DLY_W +: DLY_W]),
                .gate_on   (gate_on[i]),
                .gate_fast (gate_fast[i])
            );
        end
    endgenerate
endmodule

// File: rtl/seq_chk.sv
module seq_chk #(
    parameter int N_RAIL = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_RAIL-1:0] gate_on,
    input logic [N_RAIL-1:0] gate_fast,
    input logic              pgood,
    input logic              line_pull_low,
    input logic              line_lvl,
    input logic              good_all
);
    // R9
    line_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !line_lvl |=> (gate_on == '0));

    // R8
    uv_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!good_all && (gate_on != '0)) |=> (gate_on == '0) && (gate_fast == '1));

    // R5
    pgood_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pgood |-> (gate_on == '1));

    // R7
    rise_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((gate_on & ~$past(gate_on)) != '0) |-> !line_pull_low);

    // R6
    soft_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((~gate_on & $past(gate_on) & ~gate_fast) != '0) |-> !pgood);
endmodule

bind pwr_seq_ctrl seq_chk #(.N_RAIL(N_RAIL)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .gate_on       (gate_on),
    .gate_fast     (gate_fast),
    .pgood         (pgood),
    .line_pull_low (line_pull_low),
    .line_lvl      (line_lvl),
    .good_all      (good_all)
);

// File: tb/sim_pwr_seq_ctrl.sv
module sim_pwr_seq_ctrl;
    localparam int NR = 4;
    localparam int DW = 16;
    localparam int FC = 4;
    localparam int SC = 50;
    localparam int PC = 30;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_en_low = 1'b0;
    logic enable_in = 1'b0;
    logic [NR-1:0] uv_ok = '1;
    logic ext_line = 1'b1;
    logic line_in;
    logic [NR*DW-1:0] on_cfg  = {16'd3, 16'd10, 16'd5, 16'd0};
    logic [NR*DW-1:0] off_cfg = {16'd2, 16'd8, 16'd0, 16'd4};
    logic [NR-1:0] gate_on, gate_fast;
    logic pgood, line_pull_low;

    int on_d[NR]  = '{0, 5, 10, 3};
    int off_d[NR] = '{4, 0, 8, 2};
    int tm[NR];
    int pg_t, dl_t;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;
    assign line_in = ext_line & ~line_pull_low;

    pwr_seq_ctrl #(
        .N_RAIL(NR), .DLY_W(DW), .FILT_CYC(FC),
        .SETTLE_CYC(SC), .PGOOD_CYC(PC), .TICK_DIV(1)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_en_low(cfg_en_low), .enable_in(enable_in),
        .uv_ok(uv_ok), .line_in(line_in), .on_dly_cfg(on_cfg), .off_dly_cfg(off_cfg),
        .gate_on(gate_on), .gate_fast(gate_fast), .pgood(pgood),
        .line_pull_low(line_pull_low)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic measure(input logic want, input int limit);
        for (int i = 0; i < NR; i++) tm[i] = -1;
        pg_t = -1;
        dl_t = -1;
        for (int k = 1; k <= limit; k++) begin
            @(negedge clk);
            for (int i = 0; i < NR; i++)
                if (tm[i] < 0 && gate_on[i] == want) tm[i] = k;
            if (pg_t < 0 && pgood) pg_t = k;
            if (dl_t < 0 && line_pull_low) dl_t = k;
        end
    endtask

    task automatic wait_all_on(input int limit);
        for (int k = 0; k < limit && gate_on != '1; k++) @(negedge clk);
    endtask

    task automatic t_reset(input logic pol, input logic en);
        rst_n = 1'b0;
        cfg_en_low = pol;
        enable_in = en;
        uv_ok = '1;
        ext_line = 1'b1;
        cyc(3);
        chk(gate_on == '0, "R1 gate_on in reset", int'(gate_on), 0);
        chk(gate_fast == '1, "R1 gate_fast in reset", int'(gate_fast), 15);
        chk(pgood == 1'b0, "R1 pgood in reset", int'(pgood), 0);
        chk(line_pull_low == 1'b1, "R1 line_pull_low in reset", int'(line_pull_low), 1);
        rst_n = 1'b1;
    endtask

    task automatic t_settle();
        cyc(SC - 10);
        chk(gate_on == '0, "R3 no gate during settling", int'(gate_on), 0);
        wait_all_on(3 * SC);
        chk(gate_on == '1, "R3 gates on after settling", int'(gate_on), 15);
        cyc(PC + 5);
        chk(pgood == 1'b1, "R5 pgood after settle start", int'(pgood), 1);
    endtask

    task automatic t_soft_off();
        enable_in = ~enable_in;
        #1;
        chk(pgood == 1'b0, "R5 pgood falls with enable", int'(pgood), 0);
        measure(1'b0, 20);
        for (int i = 0; i < NR; i++)
            chk(tm[i] == off_d[i] + 2, "R6 off time", tm[i], off_d[i] + 2);
        chk(gate_fast == '0, "R6 soft mode after off", int'(gate_fast), 0);
        chk(dl_t == 10, "R7 pull-low with last gate", dl_t, 10);
    endtask

    task automatic t_seq_on(input string tag);
        enable_in = ~enable_in;
        measure(1'b1, 80);
        for (int i = 0; i < NR; i++)
            chk(tm[i] == on_d[i] + 5, {tag, " on time"}, tm[i], on_d[i] + 5);
        chk(pg_t == 15 + PC + 1, "R5 pgood delay", pg_t, 15 + PC + 1);
        chk(line_pull_low == 1'b0, "R7 line released while on", int'(line_pull_low), 1'b0);
    endtask

    task automatic t_uv_dips();
        uv_ok[2] = 1'b0;
        cyc(FC - 1);
        uv_ok[2] = 1'b1;
        cyc(5);
        chk(gate_on == '1, "R8 short dip ignored gates", int'(gate_on), 15);
        chk(pgood == 1'b1, "R8 short dip ignored pgood", int'(pgood), 1);
        uv_ok[2] = 1'b0;
        cyc(FC + 2);
        chk(gate_on == '0, "R8 long dip gates off", int'(gate_on), 0);
        chk(gate_fast == '1, "R8 long dip fast mode", int'(gate_fast), 15);
        chk(pgood == 1'b0, "R8 long dip pgood", int'(pgood), 0);
        chk(line_pull_low == 1'b1, "R7 pull-low on undervoltage", int'(line_pull_low), 1);
    endtask

    task automatic t_zero_wait();
        ext_line = 1'b0;
        uv_ok = '1;
        cyc(10);
        chk(gate_on == '0, "R10 held line keeps gates off", int'(gate_on), 0);
        ext_line = 1'b1;
        cyc(25);
        chk(gate_on == '1, "R10 zero-wait start", int'(gate_on), 15);
        cyc(PC + 5);
    endtask

    task automatic t_line_kill();
        ext_line = 1'b0;
        cyc(3);
        chk(gate_on == '0, "R9 line low kills gates", int'(gate_on), 0);
        chk(gate_fast == '1, "R9 line kill fast mode", int'(gate_fast), 15);
        cyc(5);
        ext_line = 1'b1;
        measure(1'b1, 30);
        for (int i = 0; i < NR; i++)
            chk(tm[i] == on_d[i] + 4, "R9 restart on time", tm[i], on_d[i] + 4);
    endtask

    task automatic t_polarity();
        t_reset(1'b1, 1'b1);
        cyc(2 * SC);
        chk(gate_on == '0, "R2 high input inactive when active-low", int'(gate_on), 0);
        t_seq_on("R2");
        t_soft_off();
    endtask

    initial begin
        t_reset(1'b0, 1'b1);
        t_settle();
        t_soft_off();
        t_seq_on("R4");
        t_uv_dips();
        t_zero_wait();
        t_line_kill();
        t_polarity();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule